// File: doc/BRIEF.md
# Scalar-Vector Register Decode Unit

This block holds the operand registers for a four-lane vector extension of a 32-bit RISC pipeline. It steers data between those registers and the lanes. Each instruction carries three 5-bit register specifiers. The register numbers alone decide whether the instruction is scalar, vector or mixed. Numbers 0 to 15 select entries of a 16 x 128-bit vector file, where each entry holds four 32-bit lanes. Numbers 16 to 31 select entries of a 16 x 32-bit scalar file. In the mixed form, a scalar operand is broadcast to every lane. A vector length register caps how many lanes an operation writes, counting from lane 0.

The block decodes the instruction, drives the per-lane write enables and the scalar write enable, and runs a per-lane adder and multiplier. It commits results on the next clock edge. Loads and stores are handled only up to the register side: load data arrives on input ports, store data and the effective address leave on output ports. The base address always comes from the scalar file. A combinational read port exposes any register by its 5-bit number.

Top module: `svreg_decode`

## Requirements
- R1: Register numbers 0..15 are vector, 16..31 scalar. `class_o` is 0 when no data operand is vector, 1 when all are vector, 2 when both kinds occur. ADD and MUL count rd, rs and rt as data operands; LW and LV count rd; SV counts rt; SETVL counts none.
- R2: Opcodes are ADD=0, MUL=1, LW=2, LV=3, SV=4 and SETVL=5, and 6 and 7 do nothing. With a vector rd, ADD and MUL write per lane the 32-bit wrapped sum, or the low 32 bits of the product, of the rs and rt lanes.
- R3: A scalar source in an ADD or MUL is broadcast, so its value pairs with every lane of the other operand.
- R4: A scalar rd never raises any bit of `lane_we_o`. An ADD or MUL whose operands are all scalar writes only the scalar file.
- R5: LW with a vector rd writes `ld_word_i` into lane 0 only, whatever the vector length. `lane_we_o` is then 4'b0001 and the other lanes keep their values.
- R6: LV with a vector rd writes lane l of `ld_vec_i` (bits 32l+31..32l) into each lane l below the vector length. For LW, LV and SV, `addr_o` is scalar register (16 + rs[3:0]) plus the sign-extended `imm_i`; for other opcodes it is 0.
- R7: SV asserts `st_en_o`, drives rt on `st_data_o` (a scalar rt is broadcast), sets `st_mask_o` bit l for lanes below the vector length, and writes no register.
- R8: SETVL loads the vector length with the value of scalar register (16 + rs[3:0]), limited to 4. ADD, MUL and LV leave every lane at or above the vector length unwritten, and only SETVL changes `vl_o`.
- R9: Scalar register 16 stores and returns written values like any other register.
- R10: After reset every register reads as zero and `vl_o` is 4.
- R11: An ADD or MUL with a scalar rd takes lane 0 of any vector source. LV with a scalar rd writes lane 0 of `ld_vec_i`.
- R12: `rp_data_o` returns the whole vector entry for numbers 0..15, and the scalar value zero-extended to 128 bits for numbers 16..31.
- R13: With `valid_i` low nothing is written: all write enables and `st_en_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction valid |
| op_i | input | 3 | Operation code |
| rd_i | input | 5 | Destination register number |
| rs_i | input | 5 | First source / address base register number |
| rt_i | input | 5 | Second source / store data register number |
| imm_i | input | 16 | Signed address offset |
| ld_word_i | input | 32 | Word load data |
| ld_vec_i | input | 128 | Vector load data, lane 0 in the low bits |
| rp_idx_i | input | 5 | Read port register number |
| rp_data_o | output | 128 | Read port data |
| class_o | output | 2 | Operation class |
| lane_we_o | output | 4 | Vector file lane write enables |
| scl_we_o | output | 1 | Scalar file write enable |
| addr_o | output | 32 | Effective address |
| st_en_o | output | 1 | Store enable |
| st_mask_o | output | 4 | Store lane mask |
| st_data_o | output | 128 | Store data |
| vl_o | output | 3 | Current vector length |

## Verification
ADD and MUL are swept through all eight vector/scalar combinations of rd, rs and rt at every vector length from 0 to 4. This separates the broadcast path from the lane-0 pick and shows each lane cut-off. Distinct per-lane load patterns make a lane written in error, or a lane skipped, show up on read-back. A SETVL value above four checks the limit. Word loads into a vector register with partial lengths tell the lane-0 rule apart from the length mask. Stores with vector and scalar sources, and instructions with `valid_i` low, confirm that no register changes.

// File: rtl/svreg_pkg.sv
package svreg_pkg;
  localparam logic [2:0] OP_ADD   = 3'd0;
  localparam logic [2:0] OP_MUL   = 3'd1;
  localparam logic [2:0] OP_LW    = 3'd2;
  localparam logic [2:0] OP_LV    = 3'd3;
  localparam logic [2:0] OP_SV    = 3'd4;
  localparam logic [2:0] OP_SETVL = 3'd5;

  typedef enum logic [1:0] {
    CLS_SCALAR = 2'd0,
    CLS_VECTOR = 2'd1,
    CLS_MIXED  = 2'd2
  } cls_e;
endpackage

// File: rtl/svreg_dec.sv
module svreg_dec
  import svreg_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int RIDX_W = 5,
  parameter int VL_W   = 3
) (
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [RIDX_W-1:0] rd_i,
  input  logic [RIDX_W-1:0] rs_i,
  input  logic [RIDX_W-1:0] rt_i,
  input  logic [VL_W-1:0]   vl_i,
  output cls_e              cls_o,
  output logic [LANES-1:0]  vmask_o,
  output logic [LANES-1:0]  vec_we_o,
  output logic              scl_we_o,
  output logic              rs_vec_o,
  output logic              rt_vec_o,
  output logic              mem_o,
  output logic              st_en_o,
  output logic              set_vl_o
);
  logic rd_v, rs_v, rt_v;
  logic use_rd, use_rs, use_rt;
  logic any_vec, any_scl, arith, writes;

  // top bit of the specifier selects the scalar file
  assign rd_v = ~rd_i[RIDX_W-1];
  assign rs_v = ~rs_i[RIDX_W-1];
  assign rt_v = ~rt_i[RIDX_W-1];

  assign arith  = (op_i == OP_ADD) || (op_i == OP_MUL);
  assign writes = arith || (op_i == OP_LW) || (op_i == OP_LV);

  always_comb begin
    use_rd = 1'b0;
    use_rs = 1'b0;
    use_rt = 1'b0;
    unique case (op_i)
      OP_ADD, OP_MUL: begin use_rd = 1'b1; use_rs = 1'b1; use_rt = 1'b1; end
      OP_LW, OP_LV:   use_rd = 1'b1;
      OP_SV:          use_rt = 1'b1;
      default: ;
    endcase
  end

  assign any_vec = (use_rd & rd_v) | (use_rs & rs_v) | (use_rt & rt_v);
  assign any_scl = (use_rd & ~rd_v) | (use_rs & ~rs_v) | (use_rt & ~rt_v);

  always_comb begin
    if (!any_vec)     cls_o = CLS_SCALAR;
    else if (any_scl) cls_o = CLS_MIXED;
    else              cls_o = CLS_VECTOR;
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) vmask_o[l] = (l < int'(vl_i));
  end

  always_comb begin
    vec_we_o = '0;
    if (valid_i && rd_v) begin
      if (arith || op_i == OP_LV) vec_we_o = vmask_o;
      else if (op_i == OP_LW)     vec_we_o[0] = 1'b1;
    end
  end

  assign scl_we_o = valid_i & writes & ~rd_v;
  assign rs_vec_o = rs_v;
  assign rt_vec_o = rt_v;
  assign mem_o    = (op_i == OP_LW) || (op_i == OP_LV) || (op_i == OP_SV);
  assign st_en_o  = valid_i && (op_i == OP_SV);
  assign set_vl_o = valid_i && (op_i == OP_SETVL);
endmodule

// File: rtl/svreg_lane_alu.sv
module svreg_lane_alu #(
  parameter int W = 32
) (
  input  logic         mul_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  logic [W-1:0] sum, prod;
  assign sum   = a_i + b_i;
  assign prod  = a_i * b_i;
  assign res_o = mul_i ? prod : sum;
endmodule

// File: rtl/svreg_vec_file.sv
module svreg_vec_file #(
  parameter int NREG  = 16,
  parameter int LANES = 4,
  parameter int W     = 32,
  localparam int IDX_W = $clog2(NREG),
  localparam int VW    = LANES * W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] we_i,
  input  logic [IDX_W-1:0] wa_i,
  input  logic [VW-1:0]    wd_i,
  input  logic [IDX_W-1:0] ra_a_i,
  input  logic [IDX_W-1:0] ra_b_i,
  input  logic [IDX_W-1:0] ra_c_i,
  output logic [VW-1:0]    rd_a_o,
  output logic [VW-1:0]    rd_b_o,
  output logic [VW-1:0]    rd_c_o
);
  logic [VW-1:0] mem_q [NREG];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int r = 0; r < NREG; r++) mem_q[r][l*W +: W] <= '0;
      end else if (we_i[l]) begin
        mem_q[wa_i][l*W +: W] <= wd_i[l*W +: W];
      end
    end
  end

  assign rd_a_o = mem_q[ra_a_i];
  assign rd_b_o = mem_q[ra_b_i];
  assign rd_c_o = mem_q[ra_c_i];
endmodule

// File: rtl/svreg_scl_file.sv
module svreg_scl_file #(
  parameter int NREG = 16,
  parameter int W    = 32,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wa_i,
  input  logic [W-1:0]     wd_i,
  input  logic [IDX_W-1:0] ra_a_i,
  input  logic [IDX_W-1:0] ra_b_i,
  input  logic [IDX_W-1:0] ra_c_i,
  output logic [W-1:0]     rd_a_o,
  output logic [W-1:0]     rd_b_o,
  output logic [W-1:0]     rd_c_o
);
  logic [W-1:0] mem_q [NREG];

  // entry 0 (register 16) is an ordinary storage cell
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NREG; r++) mem_q[r] <= '0;
    end else if (we_i) begin
      mem_q[wa_i] <= wd_i;
    end
  end

  assign rd_a_o = mem_q[ra_a_i];
  assign rd_b_o = mem_q[ra_b_i];
  assign rd_c_o = mem_q[ra_c_i];
endmodule

// File: rtl/svreg_decode.sv
module svreg_decode
  import svreg_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int LANES = 4,
  parameter int NREG  = 16,
  parameter int IMM_W = 16,
  localparam int IDX_W  = $clog2(NREG),
  localparam int RIDX_W = IDX_W + 1,
  localparam int VW     = LANES * XLEN,
  localparam int VL_W   = $clog2(LANES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [RIDX_W-1:0] rd_i,
  input  logic [RIDX_W-1:0] rs_i,
  input  logic [RIDX_W-1:0] rt_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [XLEN-1:0]   ld_word_i,
  input  logic [VW-1:0]     ld_vec_i,
  input  logic [RIDX_W-1:0] rp_idx_i,
  output logic [VW-1:0]     rp_data_o,
  output logic [1:0]        class_o,
  output logic [LANES-1:0]  lane_we_o,
  output logic              scl_we_o,
  output logic [XLEN-1:0]   addr_o,
  output logic              st_en_o,
  output logic [LANES-1:0]  st_mask_o,
  output logic [VW-1:0]     st_data_o,
  output logic [VL_W-1:0]   vl_o
);
  cls_e             cls;
  logic [LANES-1:0] vmask, vec_we;
  logic             scl_we, rs_vec, rt_vec, mem, st_en, set_vl;
  logic [VL_W-1:0]  vl_q;

  logic [VW-1:0]    v_rs, v_rt, v_rp, v_wd, alu_res;
  logic [XLEN-1:0]  s_rs, s_rt, s_rp, s_wd;
  logic             is_mul;

  svreg_dec #(
    .LANES (LANES),
    .RIDX_W(RIDX_W),
    .VL_W  (VL_W)
  ) u_dec (
    .valid_i (valid_i),
    .op_i    (op_i),
    .rd_i    (rd_i),
    .rs_i    (rs_i),
    .rt_i    (rt_i),
    .vl_i    (vl_q),
    .cls_o   (cls),
    .vmask_o (vmask),
    .vec_we_o(vec_we),
    .scl_we_o(scl_we),
    .rs_vec_o(rs_vec),
    .rt_vec_o(rt_vec),
    .mem_o   (mem),
    .st_en_o (st_en),
    .set_vl_o(set_vl)
  );

  svreg_vec_file #(
    .NREG (NREG),
    .LANES(LANES),
    .W    (XLEN)
  ) u_vfile (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (vec_we),
    .wa_i  (rd_i[IDX_W-1:0]),
    .wd_i  (v_wd),
    .ra_a_i(rs_i[IDX_W-1:0]),
    .ra_b_i(rt_i[IDX_W-1:0]),
    .ra_c_i(rp_idx_i[IDX_W-1:0]),
    .rd_a_o(v_rs),
    .rd_b_o(v_rt),
    .rd_c_o(v_rp)
  );

  svreg_scl_file #(
    .NREG(NREG),
    .W   (XLEN)
  ) u_sfile (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (scl_we),
    .wa_i  (rd_i[IDX_W-1:0]),
    .wd_i  (s_wd),
    .ra_a_i(rs_i[IDX_W-1:0]),
    .ra_b_i(rt_i[IDX_W-1:0]),
    .ra_c_i(rp_idx_i[IDX_W-1:0]),
    .rd_a_o(s_rs),
    .rd_b_o(s_rt),
    .rd_c_o(s_rp)
  );

  assign is_mul = (op_i == OP_MUL);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [XLEN-1:0] opa, opb;
    // scalar operands broadcast to every lane
    assign opa = rs_vec ? v_rs[l*XLEN +: XLEN] : s_rs;
    assign opb = rt_vec ? v_rt[l*XLEN +: XLEN] : s_rt;

    svreg_lane_alu #(.W(XLEN)) u_alu (
      .mul_i(is_mul),
      .a_i  (opa),
      .b_i  (opb),
      .res_o(alu_res[l*XLEN +: XLEN])
    );

    always_comb begin
      if (op_i == OP_LV)      v_wd[l*XLEN +: XLEN] = ld_vec_i[l*XLEN +: XLEN];
      else if (op_i == OP_LW) v_wd[l*XLEN +: XLEN] = ld_word_i;
      else                    v_wd[l*XLEN +: XLEN] = alu_res[l*XLEN +: XLEN];
    end

    assign st_data_o[l*XLEN +: XLEN] = opb;
  end

  // scalar result is lane 0, which already holds the lane-0 pick of a vector source
  always_comb begin
    if (op_i == OP_LW)      s_wd = ld_word_i;
    else if (op_i == OP_LV) s_wd = ld_vec_i[XLEN-1:0];
    else                    s_wd = alu_res[XLEN-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vl_q <= VL_W'(LANES);
    end else if (set_vl) begin
      if (s_rs > XLEN'(LANES)) vl_q <= VL_W'(LANES);
      else                     vl_q <= s_rs[VL_W-1:0];
    end
  end

  assign addr_o    = mem ? s_rs + XLEN'($signed(imm_i)) : '0;
  assign rp_data_o = rp_idx_i[RIDX_W-1] ? {{(VW-XLEN){1'b0}}, s_rp} : v_rp;
  assign class_o   = cls;
  assign lane_we_o = vec_we;
  assign scl_we_o  = scl_we;
  assign st_en_o   = st_en;
  assign st_mask_o = st_en ? vmask : '0;
  assign vl_o      = vl_q;
endmodule

// File: rtl/svreg_decode_chk.sv
module svreg_decode_chk #(
  parameter int LANES  = 4,
  parameter int RIDX_W = 5,
  parameter int VL_W   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic [RIDX_W-1:0] rd_i,
  input logic [LANES-1:0]  lane_we_o,
  input logic              scl_we_o,
  input logic              st_en_o,
  input logic [VL_W-1:0]   vl_o
);
  logic [LANES-1:0] lim;
  always_comb begin
    for (int l = 0; l < LANES; l++) lim[l] = (l < int'(vl_o));
  end

  AST_LANE_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i != 3'd2) |-> ((lane_we_o & ~lim) == '0)); // R8
  AST_LW_LANE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd2 && !rd_i[RIDX_W-1]) |-> (lane_we_o == LANES'(1))); // R5
  AST_SCALAR_DEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i[RIDX_W-1] |-> (lane_we_o == '0)); // R4
  AST_WE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(scl_we_o && (lane_we_o != '0))); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (lane_we_o == '0 && !scl_we_o && !st_en_o)); // R13
  AST_VL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(vl_o) <= LANES); // R8
  AST_VL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && op_i == 3'd5) |=> $stable(vl_o)); // R8
  AST_STORE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd4) |-> (lane_we_o == '0 && !scl_we_o && st_en_o)); // R7
endmodule

bind svreg_decode svreg_decode_chk #(
  .LANES (LANES),
  .RIDX_W(RIDX_W),
  .VL_W  (VL_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .op_i     (op_i),
  .rd_i     (rd_i),
  .lane_we_o(lane_we_o),
  .scl_we_o (scl_we_o),
  .st_en_o  (st_en_o),
  .vl_o     (vl_o)
);

// File: tb/svreg_decode_test.sv
module svreg_decode_test;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [2:0]   op_i = '0;
  logic [4:0]   rd_i = '0, rs_i = '0, rt_i = '0, rp_idx_i = '0;
  logic [15:0]  imm_i = '0;
  logic [31:0]  ld_word_i = '0;
  logic [127:0] ld_vec_i = '0;
  logic [127:0] rp_data_o, st_data_o;
  logic [1:0]   class_o;
  logic [3:0]   lane_we_o, st_mask_o;
  logic         scl_we_o, st_en_o;
  logic [31:0]  addr_o;
  logic [2:0]   vl_o;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] vm [16][4];
  logic [31:0] sm [16];
  int          vlm;

  svreg_decode uut (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] opnd(input int r, input int l);
    return (r < 16) ? vm[r][l] : sm[r-16];
  endfunction

  function automatic logic [3:0] lmask(input int n);
    logic [3:0] m = '0;
    for (int l = 0; l < 4; l++) if (l < n) m[l] = 1'b1;
    return m;
  endfunction

  task automatic readchk(input int idx, input string req);
    logic [127:0] e;
    if (idx < 16) e = {vm[idx][3], vm[idx][2], vm[idx][1], vm[idx][0]};
    else          e = {96'd0, sm[idx-16]};
    rp_idx_i = 5'(idx);
    #1;
    chk(rp_data_o === e, req, rp_data_o, e);
  endtask

  task automatic issue(input int op, input int rd, input int rs, input int rt,
                       input logic [15:0] imm, input logic [31:0] ldw,
                       input logic [127:0] ldv, input bit vld);
    bit ur, us, ut, av, as_;
    logic [1:0] ecls;
    logic [3:0] ewe;
    bit esw;
    logic [31:0] eaddr, nv [4], ns;
    logic [127:0] est;
    string wtag;
    @(negedge clk_i);
    valid_i = vld; op_i = 3'(op); rd_i = 5'(rd); rs_i = 5'(rs); rt_i = 5'(rt);
    imm_i = imm; ld_word_i = ldw; ld_vec_i = ldv;
    #1;
    ur = (op <= 3); us = (op <= 1); ut = (op <= 1) || (op == 4);
    av = (ur && rd < 16) || (us && rs < 16) || (ut && rt < 16);
    as_ = (ur && rd >= 16) || (us && rs >= 16) || (ut && rt >= 16);
    ecls = !av ? 2'd0 : (as_ ? 2'd2 : 2'd1);
    if (op <= 5) chk(class_o === ecls, "R1 class", 128'(class_o), 128'(ecls));
    ewe = '0;
    wtag = "R8 lane enables";
    if (vld && rd < 16) begin
      if (op <= 1 || op == 3) ewe = lmask(vlm);
      else if (op == 2) begin ewe = 4'b0001; wtag = "R5 lw lane 0"; end
    end
    if (rd >= 16) wtag = "R4 scalar dest enables";
    if (!vld) wtag = "R13 idle enables";
    if (op == 4) wtag = "R7 store enables";
    chk(lane_we_o === ewe, wtag, 128'(lane_we_o), 128'(ewe));
    esw = vld && op <= 3 && rd >= 16;
    chk(scl_we_o === esw, vld ? "R4 scalar we" : "R13 idle scalar we", 128'(scl_we_o), 128'(esw));
    eaddr = (op >= 2 && op <= 4) ? sm[rs % 16] + {{16{imm[15]}}, imm} : 32'd0;
    chk(addr_o === eaddr, "R6 address", 128'(addr_o), 128'(eaddr));
    chk(st_en_o === (vld && op == 4), "R7 store enable", 128'(st_en_o), 128'(vld && op == 4));
    if (vld && op == 4) begin
      est = {opnd(rt, 3), opnd(rt, 2), opnd(rt, 1), opnd(rt, 0)};
      chk(st_data_o === est, "R7 store data", st_data_o, est);
      chk(st_mask_o === lmask(vlm), "R7 store mask", 128'(st_mask_o), 128'(lmask(vlm)));
    end
    // compute next state from pre-edge model
    for (int l = 0; l < 4; l++) nv[l] = (rd < 16) ? vm[rd][l] : 32'd0;
    ns = (rd >= 16) ? sm[rd-16] : 32'd0;
    if (vld) begin
      case (op)
        0, 1: begin
          if (rd < 16) begin
            for (int l = 0; l < 4; l++)
              if (l < vlm) nv[l] = (op == 0) ? opnd(rs, l) + opnd(rt, l) : opnd(rs, l) * opnd(rt, l);
          end else ns = (op == 0) ? opnd(rs, 0) + opnd(rt, 0) : opnd(rs, 0) * opnd(rt, 0);
        end
        2: if (rd < 16) nv[0] = ldw; else ns = ldw;
        3: begin
          if (rd < 16) begin
            for (int l = 0; l < 4; l++) if (l < vlm) nv[l] = ldv[l*32 +: 32];
          end else ns = ldv[31:0];
        end
        default: ;
      endcase
    end
    @(posedge clk_i);
    if (vld && op <= 3) begin
      if (rd < 16) for (int l = 0; l < 4; l++) vm[rd][l] = nv[l];
      else sm[rd-16] = ns;
    end
    if (vld && op == 5) vlm = (sm[rs % 16] > 32'd4) ? 4 : int'(sm[rs % 16]);
    @(negedge clk_i);
    valid_i = 1'b0;
    chk(int'(vl_o) == vlm, "R8 vector length", 128'(vl_o), 128'(vlm));
  endtask

  function automatic logic [127:0] vpat(input int r, input int k);
    logic [127:0] v;
    for (int l = 0; l < 4; l++) v[l*32 +: 32] = 32'(r * 4099 + l * 257 + k * 31 + 3) ^ 32'h5A00_0000;
    return v;
  endfunction

  initial begin
    for (int r = 0; r < 16; r++) begin
      sm[r] = '0;
      for (int l = 0; l < 4; l++) vm[r][l] = '0;
    end
    vlm = 4;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10 reset state
    chk(vl_o === 3'd4, "R10 reset length", 128'(vl_o), 128'd4);
    for (int r = 0; r < 32; r++) readchk(r, "R10 reset zero");

    // scalars via word loads, R9 on register 16
    for (int r = 16; r < 32; r++) begin
      issue(2, r, 17, 0, 16'hFFF0, 32'(r * 65537 + 11), '0, 1);
      readchk(r, r == 16 ? "R9 scalar 16 write" : "R12 scalar read");
    end
    issue(2, 16, 16, 0, 16'h0004, 32'hDEAD_0016, '0, 1);
    readchk(16, "R9 scalar 16 rewrite");
    // vectors via full-length loads
    for (int r = 0; r < 16; r++) begin
      issue(3, r, 18, 0, 16'(r), '0, vpat(r, 0), 1);
      readchk(r, "R6 vector load");
    end

    // sweep lengths and operand kinds
    for (int v = 0; v <= 5; v++) begin
      issue(2, 31, 16, 0, 16'h0000, (v == 5) ? 32'd9 : 32'(v), '0, 1);
      issue(5, 0, 31, 0, 16'h0000, '0, '0, 1);
      for (int op = 0; op < 2; op++) begin
        for (int k = 0; k < 8; k++) begin
          int rd, rs, rt;
          rd = (k & 4) ? 20 + (v % 4) : 2 + v;
          rs = (k & 2) ? 21 + op : 8 + op;
          rt = (k & 1) ? 25 : 11;
          issue(op, rd, rs, rt, 16'h0000, '0, '0, 1);
          readchk(rd, (k == 7) ? "R4 scalar op" : (k >= 4) ? "R11 lane0 pick" :
                      (k == 0) ? "R2 lane arith" : "R3 broadcast");
        end
      end
      // partial-length loads
      issue(3, 12, 19, 0, 16'h8000, '0, vpat(12, v + 1), 1);
      readchk(12, "R8 load length mask");
      issue(2, 13, 20, 0, 16'h7FFF, 32'(v * 77 + 1), '0, 1);
      readchk(13, "R5 lw lane 0");
      // stores, vector and scalar source
      issue(4, 0, 21, 5, 16'h0010, '0, '0, 1);
      readchk(5, "R7 store no write");
      issue(4, 0, 22, 27, 16'hFF00, '0, '0, 1);
      readchk(27, "R7 store no write");
    end

    // scalar dest of vector load
    issue(3, 28, 16, 0, 16'h0001, '0, vpat(28, 9), 1);
    readchk(28, "R11 lv scalar dest");
    // invalid instruction writes nothing
    issue(0, 1, 2, 3, 16'h0000, '0, '0, 0);
    readchk(1, "R13 idle vector");
    issue(2, 30, 16, 0, 16'h0000, 32'h1234_5678, '0, 0);
    readchk(30, "R13 idle scalar");
    issue(6, 4, 4, 4, 16'h0000, '0, '0, 1);
    readchk(4, "R2 unused opcode");

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule